// File: doc/BRIEF.md
# SDRAM Command Timing Enforcer

This block sits between an SDRAM request sequencer and the stage that drives commands onto the memory pins. The sequencer presents one command (activate, read, write or precharge) with a target bank and holds it until the block accepts it. The block keeps a set of small down-counters for each bank. It raises a stall until every minimum spacing that applies to the requested command has elapsed. When the command is legal it raises a one-cycle issue strobe in the same cycle.

The spacings come from 3-bit configuration fields. A field value of zero is reserved and is treated as the longest legal spacing. The block also refuses to place two activates in a row without a column command between them. An activate to a bank that is already open is rejected with a protocol-error flag and is not issued. Every issued read starts a delay line, and that delay line produces a read-data-valid pulse exactly CAS-latency clocks later.

Top module: `sdram_te_top`

## Requirements
- R1: Commands are encoded on `req_cmd` as 00 activate, 01 read, 10 write and 11 precharge. When `req_valid` is high and no constraint applies, `cmd_issue` is high in that same cycle and `stall` stays low.
- R2: In a spacing field, the encodings 001 to 111 mean 1 to 7 clocks. The encoding 000 is reserved and means 7 clocks. With a spacing of N, the dependent command issued at cycle t is allowed at cycle t+N at the earliest.
- R3: A precharge to a bank is held until at least `cfg_ras` clocks have passed since that bank's activate.
- R4: An activate to a bank is held until at least `cfg_rp` clocks have passed since that bank's precharge.
- R5: A read or write to a bank is held until at least `cfg_rcd` clocks have passed since that bank's activate.
- R6: A precharge to a bank is also held until at least `cfg_dpl` clocks have passed since the last write to that bank. The precharge waits for whichever of R3 and R6 finishes later.
- R7: After an activate has issued, any further activate stalls until a read or write has issued.
- R8: `rd_valid` pulses exactly CL clocks after a read issues, and back-to-back reads give back-to-back pulses. In `cfg_cl`, the encodings 010 to 111 mean 2 to 7, and 000 and 001 mean 7.
- R9: An activate to an open bank raises `proto_err` in that cycle, with `cmd_issue` and `stall` both low. The bank's state is left unchanged.
- R10: `stall` is high only when `req_valid` is high and a constraint of the addressed bank (or R7) is unmet. The counters of one bank never hold back a command to another bank.
- R11: After reset, all banks are closed, no spacing is pending, no read is in flight, and all outputs are low while `req_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | SDRAM clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | A command request is present |
| req_cmd | input | 2 | Requested command code (R1) |
| req_bank | input | BANK_W (2) | Target bank |
| cfg_ras | input | 3 | Activate-to-precharge spacing field |
| cfg_rp | input | 3 | Precharge-to-activate spacing field |
| cfg_rcd | input | 3 | Activate-to-column spacing field |
| cfg_dpl | input | 3 | Write-to-precharge spacing field |
| cfg_cl | input | 3 | CAS latency field |
| cmd_issue | output | 1 | Request accepted and issued this cycle |
| stall | output | 1 | Request held back by a timing constraint |
| rd_valid | output | 1 | First read data valid |
| proto_err | output | 1 | Activate to an already open bank was rejected |

## Verification
A table-driven sequence of commands runs with fixed, short spacings. It places each request one cycle early and then exactly on time, so an off-by-one in any counter shows up as a wrong stall or issue. In the precharge rows, the write-recovery spacing finishes after the activate-to-precharge spacing. This tells apart a design that waits for both spacings from one that waits for only one. Interleaved banks show that a counter in one bank does not block another bank, and a repeated activate separates the rejection by protocol error from a stall. Directed runs then measure the actual gap lengths for a mid-range value and for the reserved encodings. They also measure the read latency at its minimum and at its reserved setting, and they check that a reset discards the open banks and any read still in flight.

// File: rtl/sdram_te_pkg.sv
package sdram_te_pkg;

  localparam int FIELD_W = 3;
  localparam int MAX_CLK = 7;

  typedef enum logic [1:0] {
    CMD_ACT = 2'b00,
    CMD_RD  = 2'b01,
    CMD_WR  = 2'b10,
    CMD_PRE = 2'b11
  } sdram_cmd_e;

  // Spacing field to counter load value (spacing minus one); 000 counts as 7.
  function automatic logic [FIELD_W-1:0] gap_load(input logic [FIELD_W-1:0] fld);
    logic [FIELD_W-1:0] v;
    v = (fld == '0) ? FIELD_W'(MAX_CLK) : fld;
    return v - 1'b1;
  endfunction

  // CAS latency field to delay-line tap (latency minus one); 000/001 count as 7.
  function automatic logic [FIELD_W-1:0] cl_tap(input logic [FIELD_W-1:0] fld);
    logic [FIELD_W-1:0] v;
    v = (fld < FIELD_W'(2)) ? FIELD_W'(MAX_CLK) : fld;
    return v - 1'b1;
  endfunction

endpackage

// File: rtl/sdram_te_cfg_decode.sv
module sdram_te_cfg_decode
  import sdram_te_pkg::*;
(
  input  logic [FIELD_W-1:0] cfg_ras,
  input  logic [FIELD_W-1:0] cfg_rp,
  input  logic [FIELD_W-1:0] cfg_rcd,
  input  logic [FIELD_W-1:0] cfg_dpl,
  input  logic [FIELD_W-1:0] cfg_cl,
  output logic [FIELD_W-1:0] ras_ld,
  output logic [FIELD_W-1:0] rp_ld,
  output logic [FIELD_W-1:0] rcd_ld,
  output logic [FIELD_W-1:0] dpl_ld,
  output logic [FIELD_W-1:0] cl_sel
);

  always_comb begin
    ras_ld = gap_load(cfg_ras);
    rp_ld  = gap_load(cfg_rp);
    rcd_ld = gap_load(cfg_rcd);
    dpl_ld = gap_load(cfg_dpl);
    cl_sel = cl_tap(cfg_cl);
  end

endmodule

// File: rtl/sdram_te_gap_timer.sv
module sdram_te_gap_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  output logic             busy
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_en)
      cnt_d = load_val;
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else
      cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);

endmodule

// File: rtl/sdram_te_bank_state.sv
module sdram_te_bank_state #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_go,
  input  logic             wr_go,
  input  logic             pre_go,
  input  logic [CNT_W-1:0] ras_ld,
  input  logic [CNT_W-1:0] rp_ld,
  input  logic [CNT_W-1:0] rcd_ld,
  input  logic [CNT_W-1:0] dpl_ld,
  output logic             act_ok,
  output logic             col_ok,
  output logic             pre_ok,
  output logic             is_open
);

  logic ras_busy, rp_busy, rcd_busy, dpl_busy;
  logic open_q, open_d;

  sdram_te_gap_timer #(.CNT_W(CNT_W)) i_ras (
    .clk(clk), .rst_n(rst_n), .load_en(act_go), .load_val(ras_ld), .busy(ras_busy));
  sdram_te_gap_timer #(.CNT_W(CNT_W)) i_rcd (
    .clk(clk), .rst_n(rst_n), .load_en(act_go), .load_val(rcd_ld), .busy(rcd_busy));
  sdram_te_gap_timer #(.CNT_W(CNT_W)) i_rp (
    .clk(clk), .rst_n(rst_n), .load_en(pre_go), .load_val(rp_ld), .busy(rp_busy));
  sdram_te_gap_timer #(.CNT_W(CNT_W)) i_dpl (
    .clk(clk), .rst_n(rst_n), .load_en(wr_go), .load_val(dpl_ld), .busy(dpl_busy));

  always_comb begin
    open_d = open_q;
    if (act_go)
      open_d = 1'b1;
    else if (pre_go)
      open_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      open_q <= 1'b0;
    else
      open_q <= open_d;
  end

  assign act_ok  = !rp_busy;
  assign col_ok  = !rcd_busy;
  assign pre_ok  = !ras_busy && !dpl_busy;
  assign is_open = open_q;

endmodule

// File: rtl/sdram_te_rd_pipe.sv
module sdram_te_rd_pipe #(
  parameter int DEPTH = 7,
  localparam int SEL_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [SEL_W-1:0] tap_sel,
  output logic             valid_out
);

  logic [DEPTH-1:0] sr_q, sr_d;

  always_comb begin
    sr_d = {sr_q[DEPTH-2:0], push};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      sr_q <= '0;
    else
      sr_q <= sr_d;
  end

  assign valid_out = sr_q[tap_sel];

endmodule

// File: rtl/sdram_te_top.sv
module sdram_te_top
  import sdram_te_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [1:0]         req_cmd,
  input  logic [BANK_W-1:0]  req_bank,
  input  logic [FIELD_W-1:0] cfg_ras,
  input  logic [FIELD_W-1:0] cfg_rp,
  input  logic [FIELD_W-1:0] cfg_rcd,
  input  logic [FIELD_W-1:0] cfg_dpl,
  input  logic [FIELD_W-1:0] cfg_cl,
  output logic               cmd_issue,
  output logic               stall,
  output logic               rd_valid,
  output logic               proto_err
);

  // Reset: asserted asynchronously, released after two clock edges.
  logic rst_meta_q, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic [FIELD_W-1:0] ras_ld, rp_ld, rcd_ld, dpl_ld, cl_sel;

  sdram_te_cfg_decode i_dec (
    .cfg_ras(cfg_ras), .cfg_rp(cfg_rp), .cfg_rcd(cfg_rcd), .cfg_dpl(cfg_dpl),
    .cfg_cl(cfg_cl), .ras_ld(ras_ld), .rp_ld(rp_ld), .rcd_ld(rcd_ld),
    .dpl_ld(dpl_ld), .cl_sel(cl_sel));

  sdram_cmd_e cmd;
  assign cmd = sdram_cmd_e'(req_cmd);

  logic [NUM_BANKS-1:0] act_ok_v, col_ok_v, pre_ok_v, open_v;
  logic [NUM_BANKS-1:0] act_go_v, wr_go_v, pre_go_v;
  logic act_pend_q, act_pend_d;
  logic blocked, err;
  logic issue_act, issue_rd, issue_wr, issue_pre;

  // Constraint selection for the addressed bank.
  always_comb begin
    err     = req_valid && (cmd == CMD_ACT) && open_v[req_bank];
    blocked = 1'b0;
    unique case (cmd)
      CMD_ACT:        blocked = !act_ok_v[req_bank] || act_pend_q;
      CMD_RD, CMD_WR: blocked = !col_ok_v[req_bank];
      CMD_PRE:        blocked = !pre_ok_v[req_bank];
      default:        blocked = 1'b1;
    endcase
  end

  assign proto_err = err;
  assign stall     = req_valid && !err && blocked;
  assign cmd_issue = req_valid && !err && !blocked;

  assign issue_act = cmd_issue && (cmd == CMD_ACT);
  assign issue_rd  = cmd_issue && (cmd == CMD_RD);
  assign issue_wr  = cmd_issue && (cmd == CMD_WR);
  assign issue_pre = cmd_issue && (cmd == CMD_PRE);

  // Activate pairing guard: set by an activate, cleared by a column command.
  always_comb begin
    act_pend_d = act_pend_q;
    if (issue_act)
      act_pend_d = 1'b1;
    else if (issue_rd || issue_wr)
      act_pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)
      act_pend_q <= 1'b0;
    else
      act_pend_q <= act_pend_d;
  end

  for (genvar gb = 0; gb < NUM_BANKS; gb++) begin : g_bank
    logic hit;
    assign hit          = (req_bank == BANK_W'(gb));
    assign act_go_v[gb] = issue_act && hit;
    assign wr_go_v[gb]  = issue_wr  && hit;
    assign pre_go_v[gb] = issue_pre && hit;

    sdram_te_bank_state #(.CNT_W(FIELD_W)) i_bank (
      .clk(clk), .rst_n(rst_sync_n),
      .act_go(act_go_v[gb]), .wr_go(wr_go_v[gb]), .pre_go(pre_go_v[gb]),
      .ras_ld(ras_ld), .rp_ld(rp_ld), .rcd_ld(rcd_ld), .dpl_ld(dpl_ld),
      .act_ok(act_ok_v[gb]), .col_ok(col_ok_v[gb]), .pre_ok(pre_ok_v[gb]),
      .is_open(open_v[gb]));
  end

  sdram_te_rd_pipe #(.DEPTH(MAX_CLK)) i_rdp (
    .clk(clk), .rst_n(rst_sync_n), .push(issue_rd),
    .tap_sel(cl_sel), .valid_out(rd_valid));

endmodule

// File: rtl/sdram_te_chk.sv
module sdram_te_chk #(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [1:0]        req_cmd,
  input logic [BANK_W-1:0] req_bank,
  input logic [2:0]        cfg_ras,
  input logic [2:0]        cfg_rp,
  input logic [2:0]        cfg_rcd,
  input logic [2:0]        cfg_dpl,
  input logic [2:0]        cfg_cl,
  input logic              cmd_issue,
  input logic              stall,
  input logic              rd_valid,
  input logic              proto_err
);

  logic [2:0] since_act [NUM_BANKS];
  logic [2:0] since_pre [NUM_BANKS];
  logic [2:0] since_wr  [NUM_BANKS];
  logic       act_last;
  logic [7:0] rd_hist;
  logic [2:0] ras_n, rp_n, rcd_n, dpl_n, cl_n;

  assign ras_n = (cfg_ras == 3'd0) ? 3'd7 : cfg_ras;
  assign rp_n  = (cfg_rp  == 3'd0) ? 3'd7 : cfg_rp;
  assign rcd_n = (cfg_rcd == 3'd0) ? 3'd7 : cfg_rcd;
  assign dpl_n = (cfg_dpl == 3'd0) ? 3'd7 : cfg_dpl;
  assign cl_n  = (cfg_cl  <= 3'd1) ? 3'd7 : cfg_cl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        since_act[b] <= 3'd7;
        since_pre[b] <= 3'd7;
        since_wr[b]  <= 3'd7;
      end
      act_last <= 1'b0;
      rd_hist  <= '0;
    end else begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        logic hit;
        hit = cmd_issue && (req_bank == BANK_W'(b));
        since_act[b] <= (hit && req_cmd == 2'b00) ? 3'd1 :
                        (since_act[b] == 3'd7) ? 3'd7 : since_act[b] + 3'd1;
        since_pre[b] <= (hit && req_cmd == 2'b11) ? 3'd1 :
                        (since_pre[b] == 3'd7) ? 3'd7 : since_pre[b] + 3'd1;
        since_wr[b]  <= (hit && req_cmd == 2'b10) ? 3'd1 :
                        (since_wr[b] == 3'd7) ? 3'd7 : since_wr[b] + 3'd1;
      end
      if (cmd_issue && req_cmd == 2'b00)
        act_last <= 1'b1;
      else if (cmd_issue && (req_cmd == 2'b01 || req_cmd == 2'b10))
        act_last <= 1'b0;
      rd_hist <= {rd_hist[6:0], cmd_issue && req_cmd == 2'b01};
    end
  end

  AST_RAS_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_issue && req_cmd == 2'b11) |-> (since_act[req_bank] >= ras_n)); // R3
  AST_RP_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_issue && req_cmd == 2'b00) |-> (since_pre[req_bank] >= rp_n)); // R4
  AST_RCD_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_issue && (req_cmd == 2'b01 || req_cmd == 2'b10)) |-> (since_act[req_bank] >= rcd_n)); // R5
  AST_DPL_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_issue && req_cmd == 2'b11) |-> (since_wr[req_bank] >= dpl_n)); // R6
  AST_NO_ACT_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_issue && req_cmd == 2'b00) |-> !act_last); // R7
  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid == rd_hist[cl_n - 3'd1]); // R8
  AST_ERR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> (!cmd_issue && !stall && req_valid && req_cmd == 2'b00)); // R9
  AST_STALL_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (req_valid && !cmd_issue)); // R10

endmodule

bind sdram_te_top sdram_te_chk #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) i_chk (
  .clk(clk), .rst_n(rst_sync_n), .req_valid(req_valid), .req_cmd(req_cmd),
  .req_bank(req_bank), .cfg_ras(cfg_ras), .cfg_rp(cfg_rp), .cfg_rcd(cfg_rcd),
  .cfg_dpl(cfg_dpl), .cfg_cl(cfg_cl), .cmd_issue(cmd_issue), .stall(stall),
  .rd_valid(rd_valid), .proto_err(proto_err));

// File: tb/test_sdram_te_top.sv
`timescale 1ns/1ps
module test_sdram_te_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_valid;
  logic [1:0] req_cmd;
  logic [1:0] req_bank;
  logic [2:0] cfg_ras, cfg_rp, cfg_rcd, cfg_dpl, cfg_cl;
  logic       cmd_issue, stall, rd_valid, proto_err;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  sdram_te_top i_sdram_te_top (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
    .req_bank(req_bank), .cfg_ras(cfg_ras), .cfg_rp(cfg_rp), .cfg_rcd(cfg_rcd),
    .cfg_dpl(cfg_dpl), .cfg_cl(cfg_cl), .cmd_issue(cmd_issue), .stall(stall),
    .rd_valid(rd_valid), .proto_err(proto_err));

  // {valid, cmd[1:0], bank[1:0], issue, stall, err, rd_valid}
  // spacings: ras 3, rp 2, rcd 2, dpl 2, cl 3
  localparam logic [8:0] VEC [0:18] = '{
    9'b1_00_00_1000, // 0  ACT b0
    9'b1_01_00_0100, // 1  RD b0 too early
    9'b1_01_00_1000, // 2  RD b0 on time
    9'b1_11_00_1000, // 3  PRE b0 on time
    9'b1_00_00_0100, // 4  ACT b0 too early
    9'b1_00_00_1001, // 5  ACT b0, read data valid
    9'b1_00_01_0100, // 6  ACT b1 with no column command between
    9'b1_10_00_1000, // 7  WR b0
    9'b1_11_00_0100, // 8  PRE b0: ras met, dpl not
    9'b1_11_00_1000, // 9  PRE b0 on time
    9'b1_00_01_1000, // 10 ACT b1
    9'b1_00_01_0010, // 11 ACT b1 again: open bank
    9'b1_00_00_0100, // 12 ACT b0 pending pair
    9'b1_01_01_1000, // 13 RD b1
    9'b1_01_01_1000, // 14 RD b1 back to back
    9'b0_00_00_0000, // 15
    9'b0_00_00_0001, // 16
    9'b0_00_00_0001, // 17
    9'b0_00_00_0000  // 18
  };

  function automatic string row_req(int i);
    case (i)
      0:          return "R1";
      1, 2, 13:   return "R5";
      3:          return "R3";
      4:          return "R4";
      5, 14, 16, 17: return "R8";
      6, 12:      return "R7";
      8, 9:       return "R6";
      11:         return "R9";
      default:    return "R10";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0;
    req_cmd   = 2'b00;
    req_bank  = 2'b00;
  endtask

  task automatic do_reset();
    @(negedge clk);
    req_valid = 1'b0;
    rst_n     = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic send_one(input logic [1:0] c, input logic [1:0] b, output bit issued);
    @(negedge clk);
    req_valid = 1'b1;
    req_cmd   = c;
    req_bank  = b;
    #1 issued = cmd_issue;
  endtask

  // Cycles from issuing (ca,ba) until (cb,bb) issues.
  task automatic measure_gap(input logic [1:0] ca, input logic [1:0] ba,
                             input logic [1:0] cb, input logic [1:0] bb, output int gap);
    bit got;
    send_one(ca, ba, got);
    gap = 0;
    for (int k = 1; k <= 12; k++) begin
      send_one(cb, bb, got);
      if (got) begin
        gap = k;
        break;
      end
    end
    idle();
  endtask

  task automatic measure_cl(output int lat);
    bit got;
    send_one(2'b00, 2'b00, got);
    send_one(2'b01, 2'b00, got);
    idle();
    lat = 0;
    for (int k = 1; k <= 12; k++) begin
      #1;
      if (rd_valid) begin
        lat = k;
        break;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R11 watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int  gap;
    bit  got;
    rst_n = 1'b0; req_valid = 1'b0; req_cmd = 2'b00; req_bank = 2'b00;
    cfg_ras = 3'd3; cfg_rp = 3'd2; cfg_rcd = 3'd2; cfg_dpl = 3'd2; cfg_cl = 3'd3;
    do_reset();

    // R11: idle outputs after reset
    #1 check({cmd_issue, stall, rd_valid, proto_err} == 4'b0000, "R11 idle after reset",
             {cmd_issue, stall, rd_valid, proto_err}, 0);

    // R10 table walk
    for (int i = 0; i < 19; i++) begin
      logic [3:0] exp4, act4;
      @(negedge clk);
      req_valid = VEC[i][8];
      req_cmd   = VEC[i][7:6];
      req_bank  = VEC[i][5:4];
      #1;
      exp4 = VEC[i][3:0];
      act4 = {cmd_issue, stall, proto_err, rd_valid};
      check(act4 == exp4, $sformatf("%s row %0d", row_req(i), i), act4, exp4);
    end

    // R2: reserved activate-to-column field means 7
    cfg_rcd = 3'd0;
    do_reset();
    measure_gap(2'b00, 2'b10, 2'b01, 2'b10, gap);
    check(gap == 7, "R2 rcd 000 gap", gap, 7);

    // R3: activate-to-precharge of 5
    cfg_rcd = 3'd1; cfg_ras = 3'd5;
    do_reset();
    measure_gap(2'b00, 2'b11, 2'b11, 2'b11, gap);
    check(gap == 5, "R3 ras 5 gap", gap, 5);

    // R6: reserved write-to-precharge field means 7
    cfg_ras = 3'd1; cfg_dpl = 3'd0;
    do_reset();
    send_one(2'b00, 2'b01, got);
    measure_gap(2'b10, 2'b01, 2'b11, 2'b01, gap);
    check(gap == 7, "R6 dpl 000 gap", gap, 7);

    // R8: CAS latency 2 and reserved 001
    cfg_dpl = 3'd1; cfg_cl = 3'd2;
    do_reset();
    measure_cl(gap);
    check(gap == 2, "R8 cl 010 latency", gap, 2);
    cfg_cl = 3'd1;
    do_reset();
    measure_cl(gap);
    check(gap == 7, "R8 cl 001 latency", gap, 7);

    // R11: reset drops open banks and in-flight reads
    cfg_cl = 3'd7;
    do_reset();
    send_one(2'b00, 2'b00, got);
    send_one(2'b01, 2'b00, got);
    do_reset();
    begin
      bit seen = 1'b0;
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        #1 if (rd_valid) seen = 1'b1;
      end
      check(!seen, "R11 read flushed", seen, 0);
    end
    send_one(2'b00, 2'b00, got);
    #1 check(got && !proto_err, "R11 bank closed after reset", {got, proto_err}, 2);
    idle();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule